// File: doc/BRIEF.md
# Evicted Line Victim Buffer

A small, fully associative store that sits beside a write-back data cache and keeps the last few whole lines that the cache threw out. When the cache misses, it probes the buffer with the line address. On a hit the buffer hands the line back and forgets it, so the cache can refill from here instead of from memory. On a miss the cache goes to memory as usual.

Lines enter through an eviction port and leave through a response port. A second output port asks memory to take a dirty line that has to be pushed out of a full buffer. The entry count is a parameter (2, 4 or 8). A second parameter picks the transfer width. In narrow mode every port moves one 32-bit word per cycle, lowest word first. In wide mode every port moves the whole line in one cycle.

Top module: `vb_victim_buffer`

## Requirements
- R1: After reset the buffer is empty: `ev_ready` and `lk_ready` are 1, `rsp_valid` and `wb_valid` are 0, and every lookup misses.
- R2: A lookup whose address equals, over all `ADDR_W` bits, the address of a held line hits and returns exactly the line data that was evicted with that address.
- R3: A hit removes the entry, so a second lookup of the same address misses.
- R4: A lookup is accepted when `lk_valid` and `lk_ready` are both 1 at a clock edge. `rsp_valid` is 1 in the very next cycle. A miss is a single beat with `rsp_hit` 0, `rsp_last` 1 and `rsp_data` all zero.
- R5: With `WIDE_XFER`=0, a line moves as `LINE_WORDS` beats in consecutive cycles. Word k sits in line bits [32k+31:32k], and the lowest word goes first. The final beat carries the last flag. On the eviction input, `ev_ready` is 1 on every beat but the last. With `WIDE_XFER`=1, a line moves in a single beat that is also the last beat.
- R6: The buffer holds up to `NUM_ENTRIES` lines (2, 4 or 8). An eviction into a full buffer displaces the entry that was evicted longest ago.
- R7: A displaced line that is clean is dropped, and no write-back request is made for it.
- R8: A displaced line that is dirty is first offered on the write-back port, with its address, in the beat order of R5. The request holds `wb_valid`, `wb_addr` and `wb_data` steady while `wb_ready` is 0. `ev_ready` stays 0 on the incoming last beat until every write-back beat has been accepted.
- R9: Sometimes a lookup is accepted in the same cycle as an eviction's last beat, and both carry the same address. In that case the lookup hits and returns the incoming line, and that line is not kept.
- R10: Removing an entry on a hit keeps the age order of the others. Later displacements still pick the oldest remaining line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Eviction beat present |
| ev_ready | output | 1 | Eviction beat accepted |
| ev_addr | input | ADDR_W | Line address of the eviction, sampled on the last beat |
| ev_dirty | input | 1 | Evicted line is dirty, sampled on the last beat |
| ev_data | input | BEAT_W | Eviction beat data |
| ev_last | input | 1 | Final beat of the eviction |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted |
| lk_addr | input | ADDR_W | Line address probed |
| rsp_valid | output | 1 | Response beat present (no backpressure) |
| rsp_hit | output | 1 | Response is a hit |
| rsp_data | output | BEAT_W | Response beat data |
| rsp_last | output | 1 | Final response beat |
| wb_valid | output | 1 | Write-back beat present |
| wb_ready | input | 1 | Write-back beat accepted by memory |
| wb_addr | output | ADDR_W | Line address being written back |
| wb_data | output | BEAT_W | Write-back beat data |
| wb_last | output | 1 | Final write-back beat |

## Verification
The hardest states to reach from the ports are the ones that need a particular past. One is a full buffer whose oldest line is dirty, while memory delays the write-back. Another is a lookup that lands exactly on the last beat of an eviction with the same address. The bench first fills the buffer with known clean lines, removes one from the middle, and refills it. It then adds dirty lines until a dirty line is the oldest, while a random `wb_ready` stretches the write-back. A directed step lines up a lookup with an eviction's final beat. After that, a long random mix of evictions and lookups over a small address pool is checked against a queue model of age order.

// File: rtl/vb_pkg.sv
`timescale 1ns/1ps
package vb_pkg;
    localparam int WORD_W = 32;

    function automatic int beats_of(input int words, input bit wide);
        return wide ? 1 : words;
    endfunction

    function automatic int beat_w_of(input int words, input bit wide);
        return wide ? words * WORD_W : WORD_W;
    endfunction

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vb_pack.sv
`timescale 1ns/1ps
// Collects incoming beats into a line, lowest beat first.
module vb_pack #(
    parameter int LINE_W = 128,
    parameter int BEAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_fire,
    input  logic              beat_last,
    input  logic [BEAT_W-1:0] beat_data,
    output logic [LINE_W-1:0] line_out
);
    localparam int BEATS = LINE_W / BEAT_W;
    localparam int CW    = vb_pkg::idx_w(BEATS);

    logic [CW-1:0]     cnt_q;
    logic [LINE_W-1:0] line_q;

    // line including the beat currently on the input
    always_comb begin
        line_out = line_q;
        line_out[cnt_q*BEAT_W +: BEAT_W] = beat_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            line_q <= '0;
        end else if (beat_fire) begin
            line_q <= line_out;
            cnt_q  <= beat_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/vb_drain.sv
`timescale 1ns/1ps
// Holds one line and sends it out beat by beat.
module vb_drain #(
    parameter int LINE_W = 128,
    parameter int BEAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              load_short,
    input  logic [LINE_W-1:0] load_line,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_last,
    output logic              can_load
);
    localparam int BEATS = LINE_W / BEAT_W;
    localparam int CW    = vb_pkg::idx_w(BEATS);

    logic              busy_q, short_q;
    logic [CW-1:0]     cnt_q;
    logic [LINE_W-1:0] line_q;
    logic              step;

    assign out_valid = busy_q;
    assign out_data  = line_q[cnt_q*BEAT_W +: BEAT_W];
    assign out_last  = busy_q && (short_q || cnt_q == CW'(BEATS-1));
    assign step      = busy_q && out_ready;
    assign can_load  = !busy_q || (step && out_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            short_q <= 1'b0;
            cnt_q   <= '0;
            line_q  <= '0;
        end else if (load) begin
            busy_q  <= 1'b1;
            short_q <= load_short;
            cnt_q   <= '0;
            line_q  <= load_line;
        end else if (step) begin
            if (out_last) busy_q <= 1'b0;
            else          cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/vb_store.sv
`timescale 1ns/1ps
// Fully associative entries with dense age ranks (0 = newest).
module vb_store #(
    parameter int N      = 4,
    parameter int ADDR_W = 26,
    parameter int LINE_W = 128
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ins_en,
    input  logic [ADDR_W-1:0]             ins_addr,
    input  logic                          ins_dirty,
    input  logic [LINE_W-1:0]             ins_line,
    input  logic                          rem_en,
    input  logic [vb_pkg::idx_w(N)-1:0]   rem_idx,
    input  logic [ADDR_W-1:0]             look_addr,
    output logic                          hit,
    output logic [vb_pkg::idx_w(N)-1:0]   hit_idx,
    output logic [LINE_W-1:0]             hit_line,
    output logic                          full,
    output logic                          old_dirty,
    output logic [ADDR_W-1:0]             old_addr,
    output logic [LINE_W-1:0]             old_line
);
    localparam int IW = vb_pkg::idx_w(N);

    logic [N-1:0]      valid, dirty;
    logic [IW-1:0]     age  [N];
    logic [ADDR_W-1:0] addr [N];
    logic [LINE_W-1:0] line [N];

    logic          free_ok;
    logic [IW-1:0] free_idx, old_idx, ins_idx, rem_age;

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_ok  = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (valid[i] && addr[i] == look_addr) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
            if (!valid[i]) begin
                free_ok  = 1'b1;
                free_idx = IW'(i);
            end
            if (valid[i] && age[i] == IW'(N-1)) old_idx = IW'(i);
        end
    end

    assign full      = !free_ok;
    assign ins_idx   = full ? old_idx : free_idx;
    assign rem_age   = age[rem_idx];
    assign hit_line  = line[hit_idx];
    assign old_dirty = dirty[old_idx];
    assign old_addr  = addr[old_idx];
    assign old_line  = line[old_idx];

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic              v_q, d_q;
        logic [IW-1:0]     a_q;
        logic [ADDR_W-1:0] ad_q;
        logic [LINE_W-1:0] l_q;
        logic              tgt, gone, older;

        assign tgt   = ins_en && ins_idx == IW'(g);
        assign gone  = rem_en && rem_idx == IW'(g);
        assign older = rem_en && a_q > rem_age;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                a_q <= '0;
            end else if (tgt) begin
                v_q <= 1'b1;
                d_q <= ins_dirty;
                a_q <= '0;
            end else if (gone) begin
                v_q <= 1'b0;
            end else if (v_q) begin
                a_q <= a_q + IW'(ins_en) - IW'(older);
            end
        end

        always_ff @(posedge clk) begin
            if (tgt) begin
                ad_q <= ins_addr;
                l_q  <= ins_line;
            end
        end

        assign valid[g] = v_q;
        assign dirty[g] = d_q;
        assign age[g]   = a_q;
        assign addr[g]  = ad_q;
        assign line[g]  = l_q;
    end
endmodule

// File: rtl/vb_victim_buffer.sv
`timescale 1ns/1ps
module vb_victim_buffer #(
    parameter int  NUM_ENTRIES = 4,
    parameter int  ADDR_W      = 26,
    parameter int  LINE_WORDS  = 4,
    parameter bit  WIDE_XFER   = 1'b0,
    localparam int LINE_W      = LINE_WORDS * vb_pkg::WORD_W,
    localparam int BEAT_W      = vb_pkg::beat_w_of(LINE_WORDS, WIDE_XFER)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ev_dirty,
    input  logic [BEAT_W-1:0] ev_data,
    input  logic              ev_last,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [BEAT_W-1:0] rsp_data,
    output logic              rsp_last,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [BEAT_W-1:0] wb_data,
    output logic              wb_last
);
    localparam int IW = vb_pkg::idx_w(NUM_ENTRIES);

    logic              ev_fire, commit, lk_fire, bypass, hit_any, wb_launch, wb_idle;
    logic              s_hit, s_full, s_old_dirty, rem_en, ins_en, rsp_hit_q;
    logic [IW-1:0]     s_hit_idx, rem_idx;
    logic [LINE_W-1:0] asm_line, s_hit_line, s_old_line, rsp_line;
    logic [ADDR_W-1:0] s_old_addr, wb_addr_q;

    assign ev_fire   = ev_valid && ev_ready;
    assign commit    = ev_fire && ev_last;
    assign lk_fire   = lk_valid && lk_ready;
    assign bypass    = lk_fire && commit && (lk_addr == ev_addr);
    assign hit_any   = bypass || s_hit;
    assign rsp_line  = bypass ? asm_line : (s_hit ? s_hit_line : '0);
    assign ev_ready  = !ev_last || (!wb_valid && !(s_full && s_old_dirty));
    assign wb_launch = ev_valid && ev_last && s_full && s_old_dirty && wb_idle && !lk_fire;
    assign ins_en    = commit && !bypass;
    assign rem_en    = (lk_fire && s_hit && !bypass) || wb_launch;
    assign rem_idx   = wb_launch ? s_old_idx_sel() : s_hit_idx;
    assign rsp_hit   = rsp_valid && rsp_hit_q;
    assign wb_addr   = wb_addr_q;

    // index of the oldest entry is the one whose address and line the store reports
    logic [IW-1:0] old_idx_w;
    function automatic logic [IW-1:0] s_old_idx_sel();
        return old_idx_w;
    endfunction
    assign old_idx_w = u_store.old_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit_q <= 1'b0;
            wb_addr_q <= '0;
        end else begin
            if (lk_fire)   rsp_hit_q <= hit_any;
            if (wb_launch) wb_addr_q <= s_old_addr;
        end
    end

    vb_pack #(.LINE_W(LINE_W), .BEAT_W(BEAT_W)) u_pack (
        .clk(clk), .rst(rst), .beat_fire(ev_fire), .beat_last(ev_last),
        .beat_data(ev_data), .line_out(asm_line)
    );

    vb_store #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst(rst), .ins_en(ins_en), .ins_addr(ev_addr), .ins_dirty(ev_dirty),
        .ins_line(asm_line), .rem_en(rem_en), .rem_idx(rem_idx), .look_addr(lk_addr),
        .hit(s_hit), .hit_idx(s_hit_idx), .hit_line(s_hit_line), .full(s_full),
        .old_dirty(s_old_dirty), .old_addr(s_old_addr), .old_line(s_old_line)
    );

    vb_drain #(.LINE_W(LINE_W), .BEAT_W(BEAT_W)) u_rsp (
        .clk(clk), .rst(rst), .load(lk_fire), .load_short(!hit_any), .load_line(rsp_line),
        .out_ready(1'b1), .out_valid(rsp_valid), .out_data(rsp_data), .out_last(rsp_last),
        .can_load(lk_ready)
    );

    vb_drain #(.LINE_W(LINE_W), .BEAT_W(BEAT_W)) u_wb (
        .clk(clk), .rst(rst), .load(wb_launch), .load_short(1'b0), .load_line(s_old_line),
        .out_ready(wb_ready), .out_valid(wb_valid), .out_data(wb_data), .out_last(wb_last),
        .can_load(wb_idle)
    );
endmodule

module vb_chk #(
    parameter int ADDR_W = 26,
    parameter int BEAT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic              ev_last,
    input logic              lk_valid,
    input logic              lk_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_last,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [BEAT_W-1:0] wb_data
);
    // R4
    lk_then_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid && lk_ready |=> rsp_valid);
    // R4
    miss_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> rsp_last);
    // R5
    rsp_burst_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_last |=> rsp_valid && rsp_hit);
    // R5
    rsp_last_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);
    // R8
    wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));
    // R8
    ev_stall_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid && ev_valid && ev_last |-> !ev_ready);
endmodule

bind vb_victim_buffer vb_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_last(ev_last),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_last(rsp_last), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .wb_data(wb_data)
);

// File: tb/vb_victim_buffer_tb.sv
`timescale 1ns/1ps
module vb_victim_buffer_tb;
    localparam int NUM = 4, AW = 26, WORDS = 4, LW = WORDS*32, BEATS = WORDS;

    logic clk = 1'b0, rst = 1'b1;
    always #4 clk = ~clk;

    logic          ev_valid = 0, ev_dirty = 0, ev_last = 0, lk_valid = 0, wb_ready = 0;
    logic [AW-1:0] ev_addr = '0, lk_addr = '0;
    logic [31:0]   ev_data = '0;
    logic          ev_ready, lk_ready, rsp_valid, rsp_hit, rsp_last, wb_valid, wb_last;
    logic [31:0]   rsp_data, wb_data;
    logic [AW-1:0] wb_addr;

    vb_victim_buffer #(.NUM_ENTRIES(NUM), .ADDR_W(AW), .LINE_WORDS(WORDS), .WIDE_XFER(1'b0)) u_dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
        .ev_dirty(ev_dirty), .ev_data(ev_data), .ev_last(ev_last), .lk_valid(lk_valid),
        .lk_ready(lk_ready), .lk_addr(lk_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_data(rsp_data), .rsp_last(rsp_last), .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_addr(wb_addr), .wb_data(wb_data), .wb_last(wb_last)
    );

    // wide-transfer instance
    logic          w_ev_valid = 0, w_lk_valid = 0;
    logic [AW-1:0] w_ev_addr = '0, w_lk_addr = '0;
    logic [LW-1:0] w_ev_data = '0;
    logic          w_ev_ready, w_lk_ready, w_rsp_valid, w_rsp_hit, w_rsp_last, w_wb_valid, w_wb_last;
    logic [LW-1:0] w_rsp_data, w_wb_data;
    logic [AW-1:0] w_wb_addr;

    vb_victim_buffer #(.NUM_ENTRIES(2), .ADDR_W(AW), .LINE_WORDS(WORDS), .WIDE_XFER(1'b1)) u_dut_wide (
        .clk(clk), .rst(rst), .ev_valid(w_ev_valid), .ev_ready(w_ev_ready), .ev_addr(w_ev_addr),
        .ev_dirty(1'b0), .ev_data(w_ev_data), .ev_last(1'b1), .lk_valid(w_lk_valid),
        .lk_ready(w_lk_ready), .lk_addr(w_lk_addr), .rsp_valid(w_rsp_valid), .rsp_hit(w_rsp_hit),
        .rsp_data(w_rsp_data), .rsp_last(w_rsp_last), .wb_valid(w_wb_valid), .wb_ready(1'b1),
        .wb_addr(w_wb_addr), .wb_data(w_wb_data), .wb_last(w_wb_last)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // model: index 0 is the oldest
    logic [AW-1:0] m_addr[$];
    logic [LW-1:0] m_line[$];
    bit            m_dirty[$];
    logic [AW-1:0] x_wb_addr[$];
    logic [LW-1:0] x_wb_line[$];

    task automatic chk(input bit ok, input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] rnd_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < m_addr.size(); i++) if (m_addr[i] == a) return i;
        return -1;
    endfunction

    // write-back monitor with random memory readiness
    initial begin
        logic [LW-1:0] wbuf;
        logic [AW-1:0] h_addr;
        logic [31:0]   h_data;
        bit            pend;
        int            wcnt;
        wbuf = '0; pend = 0; wcnt = 0; h_addr = '0; h_data = '0;
        forever begin
            @(negedge clk);
            if (pend) chk(wb_valid && wb_addr == h_addr && wb_data == h_data, "R8 hold",
                          LW'(wb_data), LW'(h_data));
            wb_ready = ($urandom % 5) < 3;
            #1;
            if (wb_valid && wb_ready && !rst) begin
                wbuf[wcnt*32 +: 32] = wb_data;
                if (wb_last) begin
                    chk(wcnt == BEATS-1, "R8 beat count", LW'(wcnt), LW'(BEATS-1));
                    if (x_wb_addr.size() == 0) chk(1'b0, "R7 unexpected write-back", LW'(wb_addr), '0);
                    else begin
                        chk(wb_addr == x_wb_addr[0], "R8 wb address", LW'(wb_addr), LW'(x_wb_addr[0]));
                        chk(wbuf == x_wb_line[0], "R8 wb line", wbuf, x_wb_line[0]);
                        void'(x_wb_addr.pop_front());
                        void'(x_wb_line.pop_front());
                    end
                    wcnt = 0;
                end else wcnt++;
            end
            pend = wb_valid && !wb_ready;
            h_addr = wb_addr;
            h_data = wb_data;
        end
    end

    task automatic do_evict(input logic [AW-1:0] a, input bit d, input logic [LW-1:0] ln);
        bit exp_wb = 0;
        int stall = 0;
        if (m_addr.size() == NUM) begin
            if (m_dirty[0]) begin
                x_wb_addr.push_back(m_addr[0]);
                x_wb_line.push_back(m_line[0]);
                exp_wb = 1;
            end
            void'(m_addr.pop_front()); void'(m_line.pop_front()); void'(m_dirty.pop_front());
        end
        m_addr.push_back(a); m_line.push_back(ln); m_dirty.push_back(d);
        @(negedge clk);
        for (int b = 0; b < BEATS; b++) begin
            bit took = 0;
            ev_valid = 1; ev_addr = a; ev_dirty = d; ev_data = ln[b*32 +: 32]; ev_last = (b == BEATS-1);
            while (!took) begin
                #2;
                took = ev_ready;
                if (!took && b < BEATS-1) chk(1'b0, "R5 non-last beat refused", 0, 1);
                @(negedge clk);
                if (!took) stall++;
                if (stall > 5000) took = 1;
            end
        end
        ev_valid = 0; ev_last = 0;
        if (exp_wb) begin
            chk(stall > 0, "R8 eviction stalled", LW'(stall), 1);
            chk(x_wb_addr.size() == 0, "R8 write-back done before commit", LW'(x_wb_addr.size()), 0);
        end
    endtask

    task automatic do_lookup(input logic [AW-1:0] a, input string tag);
        int idx = m_find(a);
        logic [LW-1:0] exp_line = '0;
        if (idx >= 0) begin
            exp_line = m_line[idx];
            m_addr.delete(idx); m_line.delete(idx); m_dirty.delete(idx);
        end
        @(negedge clk);
        lk_valid = 1; lk_addr = a;
        #2;
        chk(lk_ready, {tag, " R4 lookup ready"}, LW'(lk_ready), 1);
        @(negedge clk);
        lk_valid = 0;
        #1;
        if (idx >= 0) begin
            for (int b = 0; b < BEATS; b++) begin
                chk(rsp_valid && rsp_hit && rsp_last == (b == BEATS-1) && rsp_data == exp_line[b*32 +: 32],
                    {tag, " R2 R5 hit beat"}, LW'({rsp_valid, rsp_hit, rsp_last, rsp_data}),
                    LW'({1'b1, 1'b1, b == BEATS-1, exp_line[b*32 +: 32]}));
                if (b < BEATS-1) begin @(negedge clk); #1; end
            end
        end else begin
            chk(rsp_valid && !rsp_hit && rsp_last && rsp_data == 0, {tag, " R4 miss beat"},
                LW'({rsp_valid, rsp_hit, rsp_last, rsp_data}), LW'({1'b1, 1'b0, 1'b1, 32'h0}));
        end
    endtask

    task automatic do_bypass(input logic [AW-1:0] a, input logic [LW-1:0] ln);
        @(negedge clk);
        for (int b = 0; b < BEATS-1; b++) begin
            ev_valid = 1; ev_addr = a; ev_dirty = 1; ev_data = ln[b*32 +: 32]; ev_last = 0;
            @(negedge clk);
        end
        ev_data = ln[(BEATS-1)*32 +: 32]; ev_last = 1;
        lk_valid = 1; lk_addr = a;
        #2;
        chk(ev_ready && lk_ready, "R9 both accepted", LW'({ev_ready, lk_ready}), 3);
        @(negedge clk);
        ev_valid = 0; ev_last = 0; lk_valid = 0;
        #1;
        for (int b = 0; b < BEATS; b++) begin
            chk(rsp_valid && rsp_hit && rsp_data == ln[b*32 +: 32], "R9 bypass beat",
                LW'(rsp_data), LW'(ln[b*32 +: 32]));
            if (b < BEATS-1) begin @(negedge clk); #1; end
        end
        do_lookup(a, "R9 not kept");
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [LW-1:0] wl;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        chk(ev_ready && lk_ready && !rsp_valid && !wb_valid, "R1 reset outputs",
            LW'({ev_ready, lk_ready, rsp_valid, wb_valid}), LW'(4'b1100));
        do_lookup(26'h40, "R1");

        // wide mode: one beat carries the whole line
        wl = rnd_line();
        @(negedge clk);
        w_ev_valid = 1; w_ev_addr = 26'h77; w_ev_data = wl;
        #2; chk(w_ev_ready, "R5 wide accept", LW'(w_ev_ready), 1);
        @(negedge clk);
        w_ev_valid = 0; w_lk_valid = 1; w_lk_addr = 26'h77;
        @(negedge clk);
        w_lk_valid = 0; #1;
        chk(w_rsp_valid && w_rsp_hit && w_rsp_last && w_rsp_data == wl, "R5 wide single beat", w_rsp_data, wl);

        // fill, remove from the middle, refill, displace (clean)
        for (int k = 0; k < NUM; k++) do_evict(AW'(26'h10 + k), 1'b0, rnd_line());
        do_lookup(26'h11, "R3 first");
        do_lookup(26'h11, "R3 second");
        do_evict(26'h20, 1'b0, rnd_line());
        do_evict(26'h21, 1'b0, rnd_line());
        do_lookup(26'h10, "R10 oldest gone");
        do_lookup(26'h12, "R10 survivor");
        // dirty lines become the oldest, then get displaced
        for (int k = 0; k < NUM+2; k++) do_evict(AW'(26'h30 + k), 1'b1, rnd_line());
        do_lookup(26'h30, "R6 displaced");
        do_lookup(26'h35, "R6 newest");
        while (m_addr.size() > 0) do_lookup(m_addr[0], "R2 drain");
        do_bypass(26'h50, rnd_line());

        // random mix over a small pool
        for (int op = 0; op < 400; op++) begin
            logic [AW-1:0] a = AW'(26'h100 + ($urandom % 10));
            if (($urandom % 10) < 6) begin
                while (m_find(a) >= 0) a = AW'(26'h100 + ($urandom % 10));
                do_evict(a, 1'($urandom), rnd_line());
            end else do_lookup(a, "R6 random");
        end
        repeat (40) @(negedge clk);
        chk(x_wb_addr.size() == 0, "R8 pending write-back", LW'(x_wb_addr.size()), 0);
        done = 1;
        finish_run();
    end
endmodule